// File: doc/BRIEF.md
# Asynchronous-Acknowledge Bus Cycle Sequencer

This block turns a single-cycle internal read or write request into a fixed eight-state external bus cycle. The states are named S0 to S7, and each one lasts two system clocks. The external side drives an address bus, a data bus split into output value, output enable and input value for a pad ring to tristate, and three active-low controls: address strobe, data strobe and read/write. It also takes an active-low acknowledge from the addressed peripheral.

The strobes, the read/write level and the data drive change only on state boundaries. The acknowledge passes through a two-flop synchronizer. The sequencer checks it in the first clock of S4. If it has not arrived, the sequencer adds one two-clock wait state and checks again in the first clock of that wait state. This repeats until the acknowledge is seen. On a read, the value on the data bus is captured on the edge that enters S7. A one-clock done pulse marks the end of every cycle.

Top module: `bus_seq_master`

## Requirements
- R1: While `rst_n` is low and after its release, the outputs are as follows until a request is accepted: `bus_as_n`, `bus_ds_n` and `bus_rw_n` are 1; `bus_doe` and `rsp_done` are 0; `bus_addr` and `rsp_rdata` are 0.
- R2: A request is accepted on the rising edge at which `req` is 1 and the sequencer is idle. Counting the first clock after that edge as t=0, state Sk occupies t=2k and t=2k+1 for k = 0 to 4. S5, S6 and S7 follow after any wait states. With no waits, `rsp_done` is 1 at t=16 only.
- R3: `bus_addr` takes the request address at the start of S1 (t=2). It holds that value through the rest of the cycle and afterwards, until the next accepted cycle reaches S1.
- R4: `bus_as_n` is 0 in S2 through S6, including every wait state. It is 1 in S0, S1, S7 and when idle.
- R5: `bus_ds_n` is 0 in S4, in every wait state, in S5 and in S6. It is 1 otherwise, so it falls exactly four clocks after `bus_as_n`.
- R6: For a write (`req_rnw`=0), `bus_rw_n` is 0 from S2 through S7 and returns to 1 on the edge that ends S7. For a read (`req_rnw`=1), `bus_rw_n` stays 1 for the whole cycle.
- R7: For a write, `bus_doe` is 1 from S3 through S7, including wait states, and `bus_dout` carries the request write data while `bus_doe` is 1. For a read, `bus_doe` stays 0.
- R8: `bus_dtack_n` passes through two flip-flops. The synchronized value is checked in the first clock of S4 and in the first clock of each wait state. Let the testbench pull `bus_dtack_n` low in the clock containing the L-th falling clock edge at which `bus_as_n` is 0, and hold it low until `bus_as_n` rises. The number of inserted wait states is then 0 for L<=3 and (L-2)/2, rounded down, for L>3. Each wait state lasts two clocks and adds two clocks to the cycle.
- R9: On a read, `rsp_rdata` takes the `bus_din` value present in the last clock of S6. Later changes on `bus_din` do not alter it, and a write cycle leaves it unchanged.
- R10: `rsp_done` is a one-clock pulse in the clock after S7, with the sequencer idle. A `req` raised while a cycle is in progress is ignored: no new cycle starts, and `bus_addr` and the strobes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request; taken only when idle |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Data captured by the last read |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| bus_addr | output | ADDR_W | External address bus |
| bus_dout | output | DATA_W | Data bus output value |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Data bus input value |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw_n | output | 1 | Read/write, high = read, low = write |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
The assertions assume that wait states can only follow S4. That assumption is what makes the data strobe fall exactly four clocks after the address strobe. They also assume that the peripheral holds the acknowledge low from the moment it asserts it until the address strobe rises. The peripheral model in the bench keeps to this: it asserts the acknowledge only while the address strobe is low, keeps it low, and releases it in S7. Stray requests during a busy cycle are deliberately raised to exercise the ignore rule. All other inputs change only at falling clock edges.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [3:0] {
    B_IDLE, B_S0, B_S1, B_S2, B_S3, B_S4, B_WT, B_S5, B_S6, B_S7
  } bstate_e;

  // State reached at the end of the second clock of a state
  function automatic bstate_e step_state(bstate_e s, logic ack);
    bstate_e n;
    case (s)
      B_S0:    n = B_S1;
      B_S1:    n = B_S2;
      B_S2:    n = B_S3;
      B_S3:    n = B_S4;
      B_S4:    n = ack ? B_S5 : B_WT;
      B_WT:    n = ack ? B_S5 : B_WT;
      B_S5:    n = B_S6;
      B_S6:    n = B_S7;
      default: n = B_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic as_on(bstate_e s);
    return (s == B_S2) || (s == B_S3) || (s == B_S4) || (s == B_WT) ||
           (s == B_S5) || (s == B_S6);
  endfunction

  function automatic logic ds_on(bstate_e s);
    return (s == B_S4) || (s == B_WT) || (s == B_S5) || (s == B_S6);
  endfunction

  function automatic logic wr_low_on(bstate_e s, logic rnw);
    return !rnw && (as_on(s) || (s == B_S7));
  endfunction

  function automatic logic oe_on(bstate_e s, logic rnw);
    return !rnw && (s != B_IDLE) && (s != B_S0) && (s != B_S1) && (s != B_S2);
  endfunction

  function automatic logic ack_check(bstate_e s, logic ph);
    return ((s == B_S4) || (s == B_WT)) && !ph;
  endfunction

endpackage

// File: rtl/bus_seq_sync.sv
module bus_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  logic    ack_s,
  output bstate_e st_q,
  output bstate_e st_nxt,
  output logic    ph_q,
  output logic    ev_accept,
  output logic    ev_s1_entry,
  output logic    ev_s7_entry,
  output logic    ev_last
);
  logic ph_nxt;
  logic ack_q;
  logic ev_check;

  assign ev_accept   = (st_q == B_IDLE) && req;
  assign ev_check    = ack_check(st_q, ph_q);
  assign ev_s1_entry = (st_q == B_S0) && ph_q;
  assign ev_s7_entry = (st_q == B_S6) && ph_q;
  assign ev_last     = (st_q == B_S7) && ph_q;

  always_comb begin
    st_nxt = st_q;
    ph_nxt = 1'b0;
    if (st_q == B_IDLE) begin
      st_nxt = ev_accept ? B_S0 : B_IDLE;
    end else if (!ph_q) begin
      ph_nxt = 1'b1;
    end else begin
      st_nxt = step_state(st_q, ack_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      ph_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      ph_q <= ph_nxt;
      if (ev_check) ack_q <= ack_s;
    end
  end
endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bstate_e           st_nxt,
  input  logic              ev_accept,
  input  logic              ev_s1_entry,
  input  logic              ev_s7_entry,
  input  logic              ev_last,
  input  logic              req_rnw,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic              bus_rw_n,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done
);
  logic              rnw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign bus_dout = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnw_q   <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (ev_accept) begin
      rnw_q   <= req_rnw;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Pin levels are registered from the next state, so they change on state edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_as_n <= 1'b1;
      bus_ds_n <= 1'b1;
      bus_rw_n <= 1'b1;
      bus_doe  <= 1'b0;
      bus_addr <= '0;
      rsp_rdata <= '0;
      rsp_done <= 1'b0;
    end else begin
      bus_as_n <= !as_on(st_nxt);
      bus_ds_n <= !ds_on(st_nxt);
      bus_rw_n <= !wr_low_on(st_nxt, rnw_q);
      bus_doe  <= oe_on(st_nxt, rnw_q);
      rsp_done <= ev_last;
      if (ev_s1_entry)          bus_addr  <= addr_q;
      if (ev_s7_entry && rnw_q) rsp_rdata <= bus_din;
    end
  end
endmodule

// File: rtl/bus_seq_master.sv
module bus_seq_master
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_rnw,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_as_n,
  output logic              bus_ds_n,
  output logic              bus_rw_n,
  input  logic              bus_dtack_n
);
  bstate_e st_q;
  bstate_e st_nxt;
  logic    ph_q;
  logic    ack_s;
  logic    ev_accept;
  logic    ev_s1_entry;
  logic    ev_s7_entry;
  logic    ev_last;

  bus_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (!bus_dtack_n),
    .q (ack_s)
  );

  bus_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ack_s       (ack_s),
    .st_q        (st_q),
    .st_nxt      (st_nxt),
    .ph_q        (ph_q),
    .ev_accept   (ev_accept),
    .ev_s1_entry (ev_s1_entry),
    .ev_s7_entry (ev_s7_entry),
    .ev_last     (ev_last)
  );

  bus_seq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_nxt      (st_nxt),
    .ev_accept   (ev_accept),
    .ev_s1_entry (ev_s1_entry),
    .ev_s7_entry (ev_s7_entry),
    .ev_last     (ev_last),
    .req_rnw     (req_rnw),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .bus_din     (bus_din),
    .bus_addr    (bus_addr),
    .bus_dout    (bus_dout),
    .bus_doe     (bus_doe),
    .bus_as_n    (bus_as_n),
    .bus_ds_n    (bus_ds_n),
    .bus_rw_n    (bus_rw_n),
    .rsp_rdata   (rsp_rdata),
    .rsp_done    (rsp_done)
  );
endmodule

// File: rtl/bus_seq_checker.sv
module bus_seq_checker
  import bus_seq_pkg::*;
#(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          as_n,
  input logic          ds_n,
  input logic          rw_n,
  input logic          doe,
  input logic          done,
  input logic [AW-1:0] addr,
  input bstate_e       st,
  input logic          ph
);
  AST_DS_INSIDE_AS: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n |-> !as_n); // R5
  AST_DS_LAGS_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |-> (($past(as_n, 4) == 1'b0) && ($past(as_n, 5) == 1'b1))); // R5
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> !rw_n); // R7
  AST_RW_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !$past(as_n)) |-> $stable(rw_n)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_AS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_n) |-> ##2 done); // R10
  AST_STATE_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != B_IDLE) && !ph) |=> (st == $past(st))); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |=> $stable(addr)); // R3
endmodule

bind bus_seq_master bus_seq_checker #(.AW(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .as_n  (bus_as_n),
  .ds_n  (bus_ds_n),
  .rw_n  (bus_rw_n),
  .doe   (bus_doe),
  .done  (rsp_done),
  .addr  (bus_addr),
  .st    (st_q),
  .ph    (ph_q)
);

// File: tb/tb_bus_seq_master.sv
`timescale 1ns/1ps
module tb_bus_seq_master;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_rnw = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic          bus_doe;
  logic [DW-1:0] bus_din = '0;
  logic          bus_as_n, bus_ds_n, bus_rw_n;
  logic          bus_dtack_n = 1'b1;

  int            n_checks = 0;
  int            n_fails = 0;
  bit            finished = 0;
  logic [DW-1:0] last_rd = '0;
  logic [AW-1:0] last_addr = '0;

  always #10 clk = ~clk;

  bus_seq_master #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_rnw(req_rnw),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_as_n(bus_as_n),
    .bus_ds_n(bus_ds_n), .bus_rw_n(bus_rw_n), .bus_dtack_n(bus_dtack_n)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_waits(input int lag);
    return (lag <= 3) ? 0 : (lag - 2) / 2;
  endfunction

  // 0..7 = S0..S7, 8 = wait state, 9 = idle
  function automatic int phase_of(input int t, input int w);
    if (t < 10)        return t / 2;
    if (t < 10 + 2*w)  return 8;
    if (t < 16 + 2*w)  return (t - 2*w) / 2;
    return 9;
  endfunction

  function automatic bit e_as(input int p);
    return (p >= 2 && p <= 6) || p == 8;
  endfunction
  function automatic bit e_ds(input int p);
    return (p >= 4 && p <= 6) || p == 8;
  endfunction
  function automatic bit e_rwlow(input int p, input bit rnw);
    return !rnw && p >= 2 && p <= 8;
  endfunction
  function automatic bit e_oe(input int p, input bit rnw);
    return !rnw && p >= 3 && p <= 8;
  endfunction

  task automatic idle_chk(input int n);
    repeat (n) begin
      @(negedge clk);
      chk("R10 idle as_n", bus_as_n, 1);
      chk("R10 idle ds_n", bus_ds_n, 1);
      chk("R6 idle rw_n", bus_rw_n, 1);
      chk("R7 idle doe", bus_doe, 0);
      chk("R10 idle done", rsp_done, 0);
      chk("R3 idle addr", bus_addr, last_addr);
    end
  endtask

  // Called at a falling edge; returns at the falling edge of the done clock
  task automatic run_txn(input bit rnw, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [DW-1:0] rd, input int lag, input bit poke);
    int w;
    int k;
    int p;
    w = exp_waits(lag);
    k = 0;
    req = 1'b1; req_rnw = rnw; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    for (int t = 0; t <= 16 + 2*w; t++) begin
      p = phase_of(t, w);
      chk("R4 as_n", bus_as_n, !e_as(p));
      chk("R5 ds_n", bus_ds_n, !e_ds(p));
      chk("R6 rw_n", bus_rw_n, !e_rwlow(p, rnw));
      chk("R7 doe", bus_doe, e_oe(p, rnw));
      chk("R8 R10 done timing", rsp_done, (t == 16 + 2*w));
      if (t >= 2) chk("R3 addr", bus_addr, a);
      if (e_oe(p, rnw)) chk("R7 dout", bus_dout, wd);
      if (t == 16 + 2*w) chk("R9 rdata", rsp_rdata, rnw ? rd : last_rd);
      // peripheral model
      bus_din = (rnw && p == 6) ? rd : DW'($urandom);
      if (bus_as_n == 1'b0) begin
        k++;
        if (k == lag) bus_dtack_n = 1'b0;
      end else if (t >= 4) begin
        bus_dtack_n = 1'b1;
      end
      if (poke && t == 6) begin
        req = 1'b1; req_addr = ~a; req_rnw = ~rnw;
      end
      if (poke && t == 7) req = 1'b0;
      if (t < 16 + 2*w) @(negedge clk);
    end
    bus_dtack_n = 1'b1;
    if (rnw) last_rd = rd;
    last_addr = a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0BADC0DE));
    repeat (3) @(negedge clk);
    chk("R1 as_n in reset", bus_as_n, 1);
    chk("R1 ds_n in reset", bus_ds_n, 1);
    chk("R1 rw_n in reset", bus_rw_n, 1);
    chk("R1 doe in reset", bus_doe, 0);
    chk("R1 done in reset", rsp_done, 0);
    chk("R1 addr in reset", bus_addr, 0);
    chk("R1 rdata in reset", rsp_rdata, 0);
    rst_n = 1'b1;
    idle_chk(2);
    // directed corners
    run_txn(1'b0, 24'h12_3456, 16'hA5C3, 16'h0, 3, 1'b0);   // R8 no wait boundary
    run_txn(1'b1, 24'hFF_0001, 16'h0, 16'h7E81, 3, 1'b0);   // R2 R9 read, back-to-back
    idle_chk(1);
    run_txn(1'b1, 24'h00_00F0, 16'h0, 16'h1234, 4, 1'b0);   // R8 first wait
    run_txn(1'b0, 24'hAB_CDEF, 16'hFFFF, 16'h0, 8, 1'b1);   // R8 three waits, R10 poke
    idle_chk(6);
    run_txn(1'b1, 24'h5A_5A5A, 16'h0, 16'hFFFF, 1, 1'b0);   // early acknowledge
    run_txn(1'b0, 24'h00_0000, 16'h0001, 16'h0, 5, 1'b0);   // R9 write keeps rdata
    idle_chk(2);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      bit pk;
      pk = ($urandom_range(0, 3) == 0);
      run_txn(bit'($urandom_range(0, 1)), AW'($urandom), DW'($urandom), DW'($urandom),
              int'($urandom_range(1, 9)), pk);
      if (pk) idle_chk(6);
      else    idle_chk(int'($urandom_range(0, 2)));
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule